// File: doc/BRIEF.md
# I2C Line Conditioning Filter

This block sits between the raw SCL and SDA pins and the master and slave logic of an I2C controller. Each pin first passes through a two-flop synchronizer into the system clock domain. It then goes through a glitch filter that rejects any pulse too short to be a real bus transition. The filter is paced by a periodic tick from a programmable prescaler. The tick is a one-cycle clock enable in the system clock domain, not a separate clock. The master and slave logic use the same tick, so every consumer of the bus shares one internal rate.

The filtered level changes only after the synchronized pin has shown the same new level on two consecutive ticks. A pulse no longer than one tick period can therefore never pass. A level held for two tick periods always passes. Divisor values can be picked so that the rejection window suits 400 kHz timing and still stays within 100 kHz timing. Each change of a filtered level also raises a one-cycle rise or fall strobe. Downstream logic uses these strobes to decode bus conditions.

Top module: `i2cLineFilter`

## Requirements
- R1: While `rstN` is low and after its release, `sclOut` and `sdaOut` are 1 and all four edge strobes are 0, until a filtered change occurs.
- R2: With divisor value D, the internal tick lasts one system cycle and repeats every D+1 cycles (every cycle for D = 0). The divisor value D is an 8-bit unsigned input.
- R3: If the divisor is lowered below the prescaler's current count, a tick fires on the next cycle and the new period applies from then on. A pin change made afterwards reaches the output within the latency window of R4 for the new divisor.
- R4: Each pin is synchronized through two flops. With P = D+1, a pin level held long enough appears at its filtered output between P+3 and 2P+2 rising clock edges after the pin changes.
- R5: A low or high pulse on either pin that lasts at most P system cycles never changes the filtered output and produces no strobe.
- R6: A new level held on a pin for at least 2P system cycles always reaches the filtered output.
- R7: A rise strobe (for a 0-to-1 change) or a fall strobe (for a 1-to-0 change) is high for exactly one cycle. It is high in the same cycle in which the filtered level first shows the new value. Rise and fall of one line are never high together.
- R8: SCL and SDA are filtered independently. Opposite transitions applied to both pins in the same cycle give their strobes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divisor | input | 8 | Prescaler divisor; tick period is divisor+1 cycles |
| sclIn | input | 1 | Raw SCL pin level |
| sdaIn | input | 1 | Raw SDA pin level |
| sclOut | output | 1 | Filtered SCL level |
| sdaOut | output | 1 | Filtered SDA level |
| sclRise | output | 1 | One-cycle strobe on filtered SCL 0-to-1 |
| sclFall | output | 1 | One-cycle strobe on filtered SCL 1-to-0 |
| sdaRise | output | 1 | One-cycle strobe on filtered SDA 0-to-1 |
| sdaFall | output | 1 | One-cycle strobe on filtered SDA 1-to-0 |

## Verification
Both lines share one tick, so a falling SCL and a rising SDA can update their filtered levels and strobe on the same edge. A stale divisor count can also collide with a freshly lowered divisor in the same cycle. The bench first holds SDA low. It then flips SCL low and SDA high at the same falling clock edge, records the cycle in which each strobe is seen, and requires the two to match. For the divisor case, it lowers the divisor mid-count and then requires the next pin change to arrive inside the latency window for the new divisor.

// File: rtl/i2cFiltPkg.sv
package i2cFiltPkg;
  // strobes from the prescaler control to the filtering datapath
  typedef struct packed {
    logic tick;
  } ctlStrobes_t;
endpackage

// File: rtl/i2cFiltCtl.sv
module i2cFiltCtl
  import i2cFiltPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  output ctlStrobes_t      stb
);
  logic [DIV_W-1:0] count;
  logic             wrap;

  // >= covers a divisor lowered below the running count
  assign wrap     = (count >= divisor);
  assign stb.tick = wrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (wrap) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/i2cFiltDp.sv
module i2cFiltDp
  import i2cFiltPkg::*;
#(
  parameter int LINES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      stb,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  localparam int TOP = SYNC_STAGES - 1;

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [TOP:0] syncSh;
    logic         syncd;
    logic         prevSample;
    logic         lvlQ;
    logic         riseQ;
    logic         fallQ;
    logic         accept;

    assign syncd  = syncSh[TOP];
    assign accept = stb.tick && (syncd == prevSample) && (syncd != lvlQ);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncSh     <= '1;
        prevSample <= 1'b1;
        lvlQ       <= 1'b1;
        riseQ      <= 1'b0;
        fallQ      <= 1'b0;
      end else begin
        syncSh <= {syncSh[TOP-1:0], rawIn[g]};
        riseQ  <= 1'b0;
        fallQ  <= 1'b0;
        if (stb.tick) begin
          prevSample <= syncd;
        end
        if (accept) begin
          lvlQ  <= syncd;
          riseQ <= syncd;
          fallQ <= !syncd;
        end
      end
    end

    assign lvl[g]  = lvlQ;
    assign rise[g] = riseQ;
    assign fall[g] = fallQ;
  end
endmodule

// File: rtl/i2cLineFilter.sv
module i2cLineFilter
  import i2cFiltPkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclOut,
  output logic             sdaOut,
  output logic             sclRise,
  output logic             sclFall,
  output logic             sdaRise,
  output logic             sdaFall
);
  localparam int LINES = 2;  // bit 0 = SCL, bit 1 = SDA

  ctlStrobes_t      ctlStb;
  logic [LINES-1:0] lvlV;
  logic [LINES-1:0] riseV;
  logic [LINES-1:0] fallV;

  i2cFiltCtl #(.DIV_W(DIV_W)) uCtl (
    .clk(clk), .rstN(rstN), .divisor(divisor), .stb(ctlStb)
  );

  i2cFiltDp #(.LINES(LINES), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .rawIn({sdaIn, sclIn}),
    .lvl(lvlV), .rise(riseV), .fall(fallV)
  );

  assign sclOut  = lvlV[0];
  assign sdaOut  = lvlV[1];
  assign sclRise = riseV[0];
  assign sdaRise = riseV[1];
  assign sclFall = fallV[0];
  assign sdaFall = fallV[1];
endmodule

// File: rtl/i2cLineFilterChk.sv
module i2cLineFilterChk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic [DIV_W-1:0] divisor,
  input logic             sclOut,
  input logic             sdaOut,
  input logic             sclRise,
  input logic             sclFall,
  input logic             sdaRise,
  input logic             sdaFall
);
  // R2: with a nonzero, steady divisor the tick never lasts two cycles
  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rstN)
    (tick && divisor != '0 && $stable(divisor)) |=> (!tick || divisor == '0));

  // R5: filtered levels move only on the edge right after a tick
  a_r5_scl_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclOut) |-> $past(tick));
  a_r5_sda_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOut) |-> $past(tick));

  // R7: strobes coincide with the level change, one cycle wide, exclusive
  a_r7_sda_rise_match: assert property (@(posedge clk) disable iff (!rstN)
    sdaRise == (sdaOut && !$past(sdaOut)));
  a_r7_sda_fall_match: assert property (@(posedge clk) disable iff (!rstN)
    sdaFall == (!sdaOut && $past(sdaOut)));
  a_r7_scl_rise_match: assert property (@(posedge clk) disable iff (!rstN)
    sclRise == (sclOut && !$past(sclOut)));
  a_r7_scl_fall_match: assert property (@(posedge clk) disable iff (!rstN)
    sclFall == (!sclOut && $past(sclOut)));
  a_r7_sda_single: assert property (@(posedge clk) disable iff (!rstN)
    (sdaRise || sdaFall) |=> !(sdaRise || sdaFall));
  a_r7_scl_single: assert property (@(posedge clk) disable iff (!rstN)
    (sclRise || sclFall) |=> !(sclRise || sclFall));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(sdaRise && sdaFall) && !(sclRise && sclFall));

  // R1: strobes stay low while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_quiet: assert (!sclRise && !sclFall && !sdaRise && !sdaFall);
    end
  end
endmodule

bind i2cLineFilter i2cLineFilterChk #(.DIV_W(DIV_W)) uChk (
  .clk(clk), .rstN(rstN), .tick(ctlStb.tick), .divisor(divisor),
  .sclOut(sclOut), .sdaOut(sdaOut), .sclRise(sclRise), .sclFall(sclFall),
  .sdaRise(sdaRise), .sdaFall(sdaFall)
);

// File: tb/sim_i2cLineFilter.sv
module sim_i2cLineFilter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divisor = 8'd0;
  logic       sclIn = 1'b1;
  logic       sdaIn = 1'b1;
  logic       sclOut, sdaOut, sclRise, sclFall, sdaRise, sdaFall;

  int tests = 0;
  int fails = 0;
  int cycNum = 0;
  int sdaFallCnt = 0, sdaRiseCnt = 0, sclFallCnt = 0, sclRiseCnt = 0;
  int lastSdaFall = -1, lastSdaRise = -1, lastSclFall = -1;
  int dblStrobe = 0;
  int bothSameLine = 0;
  logic prevAny = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  i2cLineFilter u0 (
    .clk(clk), .rstN(rstN), .divisor(divisor), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclOut(sclOut), .sdaOut(sdaOut), .sclRise(sclRise), .sclFall(sclFall),
    .sdaRise(sdaRise), .sdaFall(sdaFall)
  );

  // monitor samples 2 ns after each rising edge
  always @(posedge clk) begin
    cycNum++;
    #2;
    if (sdaFall) begin sdaFallCnt++; lastSdaFall = cycNum; end
    if (sdaRise) begin sdaRiseCnt++; lastSdaRise = cycNum; end
    if (sclFall) begin sclFallCnt++; lastSclFall = cycNum; end
    if (sclRise) sclRiseCnt++;
    if (prevAny && (sdaFall || sdaRise)) dblStrobe++;
    if ((sdaRise && sdaFall) || (sclRise && sclFall)) bothSameLine++;
    prevAny = sdaFall || sdaRise;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [7:0] d);
    @(negedge clk);
    rstN = 1'b0; divisor = d; sclIn = 1'b1; sdaIn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // {useScl, divisor, width, expectPass}
  typedef struct packed { logic useScl; logic [7:0] d; logic [15:0] w; logic pass; } vec_t;
  localparam vec_t VECS [12] = '{
    '{1'b0, 8'd0,  16'd1,  1'b0}, '{1'b0, 8'd0,  16'd2,  1'b1},
    '{1'b0, 8'd3,  16'd4,  1'b0}, '{1'b0, 8'd3,  16'd8,  1'b1},
    '{1'b1, 8'd7,  16'd8,  1'b0}, '{1'b1, 8'd7,  16'd16, 1'b1},
    '{1'b0, 8'd20, 16'd21, 1'b0}, '{1'b0, 8'd20, 16'd42, 1'b1},
    '{1'b1, 8'd1,  16'd2,  1'b0}, '{1'b1, 8'd1,  16'd4,  1'b1},
    '{1'b0, 8'd5,  16'd3,  1'b0}, '{1'b1, 8'd255,16'd512,1'b1}
  };

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycNum, 0);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    doReset(8'd2);
    #1;
    check(sclOut && sdaOut, "R1 idle-high after reset", {sclOut, sdaOut}, 3);
    check(!(sclRise || sclFall || sdaRise || sdaFall), "R1 strobes low",
          {sclRise, sclFall, sdaRise, sdaFall}, 0);

    // R5/R6 vector table
    foreach (VECS[i]) begin
      int f0, r0, p;
      doReset(VECS[i].d);
      repeat (5) @(negedge clk);
      f0 = VECS[i].useScl ? sclFallCnt : sdaFallCnt;
      r0 = VECS[i].useScl ? sclRiseCnt : sdaRiseCnt;
      if (VECS[i].useScl) sclIn = 1'b0; else sdaIn = 1'b0;
      repeat (VECS[i].w) @(negedge clk);
      sclIn = 1'b1; sdaIn = 1'b1;
      p = VECS[i].d + 1;
      repeat (3 * p + 8) @(negedge clk);
      f0 = (VECS[i].useScl ? sclFallCnt : sdaFallCnt) - f0;
      r0 = (VECS[i].useScl ? sclRiseCnt : sdaRiseCnt) - r0;
      if (VECS[i].pass) begin
        check(f0 == 1 && r0 == 1, "R6 held level propagates", f0 * 10 + r0, 11);
      end else begin
        check(f0 == 0 && r0 == 0, "R5 short pulse rejected", f0 * 10 + r0, 0);
      end
      check(sclOut && sdaOut, "R5 line back idle", {sclOut, sdaOut}, 3);
    end

    // R2/R4: latency window for several divisors
    for (int k = 0; k < 4; k++) begin
      int d, c0, lat;
      d = (k == 0) ? 0 : (k == 1) ? 3 : (k == 2) ? 9 : 30;
      doReset(d[7:0]);
      repeat (2 + k) @(negedge clk);
      c0 = cycNum;
      sdaIn = 1'b0;
      repeat (2 * (d + 1) + 6) @(negedge clk);
      lat = lastSdaFall - c0;
      check(lat >= d + 4 && lat <= 2 * d + 4, "R2 R4 fall latency window", lat, d + 4);
      check(!sdaOut, "R4 filtered low", sdaOut, 0);
    end

    // R3: divisor lowered mid-count
    begin
      int c0, lat;
      doReset(8'd200);
      repeat (100) @(negedge clk);
      divisor = 8'd2;
      repeat (5) @(negedge clk);
      c0 = cycNum;
      sdaIn = 1'b0;
      repeat (20) @(negedge clk);
      lat = lastSdaFall - c0;
      check(lat >= 6 && lat <= 8, "R3 new divisor takes effect", lat, 6);
    end

    // R8: SCL falls and SDA rises in the same cycle
    begin
      doReset(8'd4);
      sdaIn = 1'b0;
      repeat (20) @(negedge clk);
      check(!sdaOut && sclOut, "R8 setup sda low scl high", {sclOut, sdaOut}, 2);
      sclIn = 1'b0; sdaIn = 1'b1;
      repeat (20) @(negedge clk);
      check(lastSclFall == lastSdaRise && lastSclFall > 0, "R8 simultaneous strobes",
            lastSclFall, lastSdaRise);
      check(!sclOut && sdaOut, "R8 final levels", {sclOut, sdaOut}, 1);
    end

    // R7: strobe width and exclusivity over the whole run
    check(dblStrobe == 0, "R7 strobes one cycle wide", dblStrobe, 0);
    check(bothSameLine == 0, "R7 rise/fall exclusive", bothSameLine, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule